// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a small packet memory carved into fixed 256-byte pages. A host sends 16-bit command words. The operation code sits in bits [7:5]. The block then grants a packet number together with the pages behind it, gives that number back, or moves packet numbers through three queues. The queues are a receive queue filled by the receive path, a transmit-pending queue filled by the host, and a transmit-completion queue filled as the transmitter finishes frames. The block does not touch packet data. It only tracks which page belongs to which packet number and in what order packet numbers are handed on.

An allocation is decided in the cycle that carries the command. It either grants the lowest free packet number and the lowest free pages, or it reports failure and changes nothing else. Giving pages back is a walk over the page table, one page per cycle. During that walk a busy flag is high and every command except the full reset is ignored. The host reads the allocation result byte, a memory-info word, a queue-heads word and the busy flag. It also gets a one-cycle interrupt pulse when an allocation is granted.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset the allocation result reads 0x80, the memory-info word reads free = total = NUM_PAGES, the queue-heads word reads 0x8080, busy is low and the transmit-pending queue is empty.
- R2: Operation code 1 in bits [7:5] with pages-minus-one in the low log2(NUM_PAGES) bits succeeds when enough pages and a packet number are free. On the next cycle the result byte holds the lowest free packet number with bit 7 clear, the free count has dropped by the page count, and alloc_irq is high for exactly one cycle.
- R3: An allocation that asks for more pages than are free, or that finds no free packet number, sets the result to 0x80, raises no interrupt and leaves the free count unchanged.
- R4: A granted packet number is not granted again until it has been freed. After it is freed it is again the lowest candidate.
- R5: Operation code 5 frees every page of the packet number on pkt_sel. Busy stays high for NUM_PAGES cycles, starting the cycle after the command. While busy, commands other than code 2 have no effect. At the end the pages are counted free again.
- R6: A pulse on rx_done appends rx_pkt to the receive queue. The queue-heads word shows the oldest entry in bits [14:8] and bit 15 = 1 when the queue is empty.
- R7: Operation code 3 drops the receive-queue head and leaves its pages allocated.
- R8: Operation code 4 drops the receive-queue head and frees its pages, with the same busy walk as R5.
- R9: Operation code 6 appends pkt_sel to the transmit-pending queue. Each tx_sent pulse moves the pending head to the completion queue, in the same order. The completion head appears in bits [6:0] of the queue-heads word, with bit 7 = 1 when that queue is empty. tx_ack drops the completion head.
- R10: Operation code 7 empties both transmit queues and leaves pages and the receive queue unchanged.
- R11: Operation code 2 returns all pages and packet numbers and empties all queues on the next cycle, even while busy.
- R12: Operation code 0 changes no output.
- R13: mem_info carries the free page count in bits [15:8] and the total page count in bits [7:0]. Free never exceeds total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | Command: op in [7:5], page count minus one in low bits |
| pkt_sel | input | 7 | Packet number used by free and transmit-enqueue commands |
| rx_done | input | 1 | Receive path completed a packet |
| rx_pkt | input | 7 | Packet number of that received packet |
| tx_sent | input | 1 | Transmitter finished the pending head |
| tx_ack | input | 1 | Host consumed the completion head |
| alloc_result | output | 8 | Bit 7 = failure, else granted packet number |
| alloc_irq | output | 1 | One-cycle pulse on a granted allocation |
| busy | output | 1 | Page release walk in progress |
| mem_info | output | 16 | Free pages [15:8], total pages [7:0] |
| queue_heads | output | 16 | RX empty, RX head, TX-done empty, TX-done head |
| tx_pend_empty | output | 1 | Transmit-pending queue empty |
| tx_pend_pkt | output | 7 | Packet number at the transmit-pending head |

## Verification
The properties assume that the host issues at most one command per cycle and does not pulse tx_sent or tx_ack against an empty queue. The idle-command and drop-without-free properties also assume that rx_done, tx_sent and tx_ack stay low in the same cycle, because those inputs legally move the queue word on their own. The stimulus keeps to this. Every command is a single-cycle pulse with the side inputs held low, and queue pulses are issued only when the model knows the target queue holds entries. Commands meant to be ignored are issued only after busy has been seen high.

// File: rtl/pga_pkg.sv
package pga_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ALLOC    = 3'd1,
        OP_CLEAR    = 3'd2,
        OP_RX_DROP  = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_FREE     = 3'd5,
        OP_TX_QUEUE = 3'd6,
        OP_TX_CLEAR = 3'd7
    } op_e;

    localparam logic [7:0] RES_FAIL = 8'h80;

    typedef struct packed {
        logic       rx_none;
        logic [6:0] rx_pkt;
        logic       tx_none;
        logic [6:0] tx_pkt;
    } heads_t;

    function automatic op_e op_of(input logic [15:0] w);
        return op_e'(w[7:5]);
    endfunction

endpackage

// File: rtl/pga_pkt_fifo.sv
module pga_pkt_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic         empty,
    output logic         full,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = empty ? '0 : mem[rd_p];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_p] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wr_p <= step(wr_p);
            if (do_pop)  rd_p <= step(rd_p);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/pga_pkt_pool.sv
module pga_pkt_pool #(
    parameter int NUM_PKTS = 8,
    parameter int PW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          take,
    input  logic          ret,
    input  logic [PW-1:0] ret_pkt,
    output logic          any_free,
    output logic [PW-1:0] first_free
);
    logic [NUM_PKTS-1:0] used;

    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int i = NUM_PKTS - 1; i >= 0; i--) begin
            if (!used[i]) begin
                any_free   = 1'b1;
                first_free = PW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used <= '0;
        end else begin
            for (int i = 0; i < NUM_PKTS; i++) begin
                if (take && first_free == PW'(i))
                    used[i] <= 1'b1;
                else if (ret && ret_pkt == PW'(i))
                    used[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pga_page_map.sv
module pga_page_map #(
    parameter int NUM_PAGES = 16,
    parameter int PW        = 3,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          alloc_go,
    input  logic [CW-1:0] alloc_n,
    input  logic [PW-1:0] alloc_pkt,
    input  logic          rel_go,
    input  logic [PW-1:0] rel_pkt,
    output logic          busy,
    output logic          rel_done,
    output logic [PW-1:0] rel_tag,
    output logic [CW-1:0] free_cnt
);
    localparam int IW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic [NUM_PAGES-1:0] owned, grab;
    logic [PW-1:0]        owner [NUM_PAGES];
    logic [CW-1:0]        seen;
    logic [IW-1:0]        idx;
    logic                 active, hit;

    // Lowest free pages are claimed: a page is taken when fewer than
    // alloc_n free pages sit below it.
    always_comb begin
        seen = '0;
        grab = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (!owned[i]) begin
                grab[i] = alloc_go && (seen < alloc_n);
                seen    = seen + 1'b1;
            end
        end
    end

    assign hit      = active && owned[idx] && (owner[idx] == rel_tag);
    assign busy     = active;
    assign rel_done = active && (idx == IW'(NUM_PAGES - 1));

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PAGES; i++)
            if (grab[i]) owner[i] <= alloc_pkt;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            owned    <= '0;
            active   <= 1'b0;
            idx      <= '0;
            rel_tag  <= '0;
            free_cnt <= CW'(NUM_PAGES);
        end else begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                if (grab[i])
                    owned[i] <= 1'b1;
                else if (hit && idx == IW'(i))
                    owned[i] <= 1'b0;
            end
            if (alloc_go)
                free_cnt <= free_cnt - alloc_n;
            else if (hit)
                free_cnt <= free_cnt + 1'b1;
            if (rel_go) begin
                active  <= 1'b1;
                idx     <= '0;
                rel_tag <= rel_pkt;
            end else if (active) begin
                if (idx == IW'(NUM_PAGES - 1))
                    active <= 1'b0;
                else
                    idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
    parameter int NUM_PAGES = 16,
    parameter int NUM_PKTS  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic [6:0]  pkt_sel,
    input  logic        rx_done,
    input  logic [6:0]  rx_pkt,
    input  logic        tx_sent,
    input  logic        tx_ack,
    output logic [7:0]  alloc_result,
    output logic        alloc_irq,
    output logic        busy,
    output logic [15:0] mem_info,
    output logic [15:0] queue_heads,
    output logic        tx_pend_empty,
    output logic [6:0]  tx_pend_pkt
);
    import pga_pkg::*;

    localparam int PW = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
    localparam int CW = $clog2(NUM_PAGES + 1);
    localparam int NW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    op_e           op;
    logic          live, clear, alloc_try, alloc_ok;
    logic [CW-1:0] need, free_cnt;
    logic          any_free;
    logic [PW-1:0] first_free, rel_tag, rel_pkt;
    logic          rel_go, rel_done;
    logic          rx_empty, rx_full, rx_pop;
    logic [PW-1:0] rx_head;
    logic          pend_full, pend_push;
    logic [PW-1:0] pend_head;
    logic          done_empty, done_full, tx_clr;
    logic [PW-1:0] done_head;
    heads_t        heads;

    assign op        = op_of(cmd_word);
    assign live      = cmd_valid && !busy;
    assign clear     = cmd_valid && (op == OP_CLEAR);
    assign need      = CW'(cmd_word[NW-1:0]) + 1'b1;
    assign alloc_try = live && (op == OP_ALLOC);
    assign alloc_ok  = alloc_try && any_free && (free_cnt >= need);
    assign rx_pop    = live && !rx_empty &&
                       ((op == OP_RX_DROP) || (op == OP_RX_FREE));
    assign rel_go    = live && (((op == OP_RX_FREE) && !rx_empty) ||
                                (op == OP_FREE));
    assign rel_pkt   = (op == OP_FREE) ? pkt_sel[PW-1:0] : rx_head;
    assign pend_push = live && (op == OP_TX_QUEUE);
    assign tx_clr    = clear || (live && (op == OP_TX_CLEAR));

    pga_page_map #(.NUM_PAGES(NUM_PAGES), .PW(PW), .CW(CW)) i_map (
        .clk(clk), .rst(rst), .clr(clear),
        .alloc_go(alloc_ok), .alloc_n(need), .alloc_pkt(first_free),
        .rel_go(rel_go), .rel_pkt(rel_pkt),
        .busy(busy), .rel_done(rel_done), .rel_tag(rel_tag),
        .free_cnt(free_cnt)
    );

    pga_pkt_pool #(.NUM_PKTS(NUM_PKTS), .PW(PW)) i_pool (
        .clk(clk), .rst(rst), .clr(clear),
        .take(alloc_ok), .ret(rel_done), .ret_pkt(rel_tag),
        .any_free(any_free), .first_free(first_free)
    );

    pga_pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) i_rxq (
        .clk(clk), .rst(rst), .clr(clear),
        .push(rx_done), .pop(rx_pop), .din(rx_pkt[PW-1:0]),
        .empty(rx_empty), .full(rx_full), .head(rx_head)
    );

    pga_pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) i_pendq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(pend_push), .pop(tx_sent), .din(pkt_sel[PW-1:0]),
        .empty(tx_pend_empty), .full(pend_full), .head(pend_head)
    );

    pga_pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) i_doneq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(tx_sent && !tx_pend_empty), .pop(tx_ack), .din(pend_head),
        .empty(done_empty), .full(done_full), .head(done_head)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            alloc_result <= RES_FAIL;
            alloc_irq    <= 1'b0;
        end else begin
            alloc_irq <= alloc_ok;
            if (alloc_try)
                alloc_result <= alloc_ok ? {1'b0, 7'(first_free)} : RES_FAIL;
        end
    end

    always_comb begin
        heads.rx_none = rx_empty;
        heads.rx_pkt  = 7'(rx_head);
        heads.tx_none = done_empty;
        heads.tx_pkt  = 7'(done_head);
    end

    assign queue_heads = heads;
    assign mem_info    = {8'(free_cnt), 8'(NUM_PAGES)};
    assign tx_pend_pkt = 7'(pend_head);
endmodule

// File: rtl/pga_checker.sv
module pga_checker #(
    parameter int NUM_PAGES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic        rx_done,
    input logic        tx_sent,
    input logic        tx_ack,
    input logic [7:0]  alloc_result,
    input logic        alloc_irq,
    input logic        busy,
    input logic [15:0] mem_info,
    input logic [15:0] queue_heads,
    input logic        tx_pend_empty
);
    localparam int NW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic [2:0] code;
    logic [8:0] need;
    logic       quiet;

    assign code  = cmd_word[7:5];
    assign need  = 9'(cmd_word[NW-1:0]) + 9'd1;
    assign quiet = !rx_done && !tx_sent && !tx_ack;

    AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        alloc_irq |-> !alloc_result[7]);  // R2

    AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && code == 3'd1 && 9'(mem_info[15:8]) < need)
        |=> (alloc_result == 8'h80 && !alloc_irq && $stable(mem_info)));  // R3

    AST_RELEASE_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
        busy |=> mem_info[15:8] >= $past(mem_info[15:8]));  // R5

    AST_RX_DROP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && code == 3'd3 && quiet) |=> $stable(mem_info));  // R7

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && code == 3'd7) |=> (queue_heads[7] && tx_pend_empty));  // R10

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && code == 3'd2)
        |=> (mem_info[15:8] == mem_info[7:0] && queue_heads[15] &&
             queue_heads[7] && tx_pend_empty && !busy));  // R11

    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && code == 3'd0 && quiet)
        |=> ($stable(queue_heads) && $stable(mem_info) && $stable(alloc_result)));  // R12

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        mem_info[15:8] <= mem_info[7:0]);  // R13
endmodule

bind pkt_page_alloc pga_checker #(.NUM_PAGES(NUM_PAGES)) i_pga_checker (.*);

// File: tb/test_pkt_page_alloc.sv
`timescale 1ns/1ps
module test_pkt_page_alloc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [6:0]  pkt_sel = '0;
    logic        rx_done = 1'b0;
    logic [6:0]  rx_pkt = '0;
    logic        tx_sent = 1'b0;
    logic        tx_ack = 1'b0;
    logic [7:0]  alloc_result;
    logic        alloc_irq, busy, tx_pend_empty;
    logic [15:0] mem_info, queue_heads;
    logic [6:0]  tx_pend_pkt;

    pkt_page_alloc i_pkt_page_alloc (.*);

    always #4 clk = ~clk;

    typedef struct {
        int          sel;
        logic [15:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    event ev;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   ended = 0;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            0: return {8'h00, alloc_result};
            1: return {8'h00, mem_info[15:8]};
            2: return queue_heads;
            3: return {15'd0, busy};
            4: return {15'd0, alloc_irq};
            5: return mem_info;
            default: return {8'h00, tx_pend_empty, tx_pend_pkt};
        endcase
    endfunction

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (observe(e.sel) !== e.val) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h",
                             e.req, e.sel, observe(e.sel), e.val);
                end
            end
        end
    end

    task automatic expect_val(int sel, logic [15:0] val, string req);
        exp_t e;
        e.sel = sel; e.val = val; e.req = req;
        q.push_back(e);
        -> ev;
    endtask

    task automatic issue(logic [15:0] w, logic [6:0] s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = w; pkt_sel = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rx_push(logic [6:0] p);
        @(negedge clk); rx_done = 1'b1; rx_pkt = p;
        @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic tx_step(bit ack);
        @(negedge clk);
        if (ack) tx_ack = 1'b1; else tx_sent = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0; tx_sent = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 64 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_val(0, 16'h0080, "R1");
        expect_val(5, 16'h1010, "R1 R13");
        expect_val(2, 16'h8080, "R1");
        expect_val(3, 16'h0000, "R1");
        expect_val(6, 16'h0080, "R1");

        // R2 allocate 4 pages, then 8 pages
        issue(16'h0023, 7'd0);
        expect_val(0, 16'h0000, "R2");
        expect_val(4, 16'h0001, "R2");
        expect_val(1, 16'd12, "R2");
        @(negedge clk);
        expect_val(4, 16'h0000, "R2");
        issue(16'h0027, 7'd0);
        expect_val(0, 16'h0001, "R2");
        expect_val(1, 16'd4, "R2");

        // R3 too few pages
        issue(16'h0024, 7'd0);
        expect_val(0, 16'h0080, "R3");
        expect_val(4, 16'h0000, "R3");
        expect_val(1, 16'd4, "R3");

        // R12 no-op
        issue(16'h0000, 7'd0);
        expect_val(0, 16'h0080, "R12");
        expect_val(5, 16'h0410, "R12 R13");
        expect_val(2, 16'h8080, "R12");

        // R5 free packet 0, command during busy ignored
        issue(16'h00A0, 7'd0);
        expect_val(3, 16'h0001, "R5");
        issue(16'h0020, 7'd0);
        expect_val(0, 16'h0080, "R5");
        expect_val(4, 16'h0000, "R5");
        wait_idle();
        expect_val(1, 16'd8, "R5");

        // R4 freed number reused, used number skipped
        issue(16'h0021, 7'd0);
        expect_val(0, 16'h0000, "R4");
        expect_val(1, 16'd6, "R4");
        issue(16'h0020, 7'd0);
        expect_val(0, 16'h0002, "R4");
        expect_val(1, 16'd5, "R4");

        // R6 receive queue order
        rx_push(7'd1);
        rx_push(7'd2);
        expect_val(2, 16'h0180, "R6");

        // R7 drop without free
        issue(16'h0060, 7'd0);
        expect_val(2, 16'h0280, "R7");
        expect_val(1, 16'd5, "R7");

        // R8 drop and free
        issue(16'h0080, 7'd0);
        expect_val(3, 16'h0001, "R8");
        wait_idle();
        expect_val(2, 16'h8080, "R8");
        expect_val(1, 16'd6, "R8");

        // R9 transmit queues keep order
        issue(16'h00C0, 7'd1);
        issue(16'h00C0, 7'd0);
        expect_val(6, 16'h0001, "R9");
        expect_val(2, 16'h8080, "R9");
        tx_step(0);
        expect_val(2, 16'h8001, "R9");
        expect_val(6, 16'h0000, "R9");
        tx_step(0);
        expect_val(2, 16'h8001, "R9");
        expect_val(6, 16'h0080, "R9");
        tx_step(1);
        expect_val(2, 16'h8000, "R9");
        tx_step(1);
        expect_val(2, 16'h8080, "R9");

        // R10 transmit clear
        issue(16'h00C0, 7'd1);
        tx_step(0);
        issue(16'h00C0, 7'd0);
        expect_val(2, 16'h8001, "R10");
        issue(16'h00E0, 7'd0);
        expect_val(2, 16'h8080, "R10");
        expect_val(6, 16'h0080, "R10");
        expect_val(1, 16'd6, "R10");

        // R11 full reset during a release
        rx_push(7'd0);
        expect_val(2, 16'h0080, "R11");
        issue(16'h00A0, 7'd1);
        expect_val(3, 16'h0001, "R11");
        issue(16'h0040, 7'd0);
        expect_val(5, 16'h1010, "R11");
        expect_val(2, 16'h8080, "R11");
        expect_val(3, 16'h0000, "R11");
        expect_val(0, 16'h0080, "R11");

        // R3 / R4 packet numbers exhausted
        for (int k = 0; k < 8; k++) begin
            issue(16'h0020, 7'd0);
            expect_val(0, 16'(k), "R4");
        end
        issue(16'h0020, 7'd0);
        expect_val(0, 16'h0080, "R3");
        expect_val(5, 16'h0810, "R3");

        #1;
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule